// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the delivery state for a bank of interrupt sources that are treated as level-style inputs. Every source owns a two-bit state, a software-written destination and a delivery priority. The destination is either one CPU thread or a shared queue served by every online thread. When a source with a usable priority is signalled, the block sends one request toward the CPU side. The request names the source and carries its priority and destination.

The CPU side answers each request with accept or reject. An accepted source waits in the pending state, and it is not presented again until software sends an end-of-interrupt (EOI) naming it. A rejected source stays armed. Its retry holdoff timer is loaded, and the block sends the request again once the timer has run out. Only one request is outstanding at a time. When several sources are ready together, the lowest source number goes first. A small write port sets the priority and destination of one source per cycle.

Top module: `irq_src_ctrl`

## Requirements
- R1: A synchronous active-high reset puts every source in the idle state and every priority at the disabled value, which is all ones (15 with 4-bit priorities). After reset no request is raised, even when a source is signalled.
- R2: A signal on an idle source with an enabled priority raises `req_valid` on the second rising edge after the signal is sampled. The request carries the source number, the priority, the global flag and the CPU number.
- R3: While `req_valid` is high and no response is given, the request fields hold steady. `req_valid` drops on the edge that samples `rsp_accept` or `rsp_reject`.
- R4: An accepted source moves to the pending state. Further signals on it raise no request until an EOI names it.
- R5: An EOI naming a pending source returns it to idle. If the signal is still high, or is raised again, the source raises a new request.
- R6: A rejected source raises its request again on rising edge RETRY_HOLD+1 after the rejecting edge (edge 17 with the default of 16).
- R7: When several sources are ready in the same cycle, the request goes to the lowest source number, whatever the priorities.
- R8: A source whose priority is the disabled value never raises a request but still latches its signal. If an enabled priority is written to it later, its request appears on the edge after the write, with no new signal.
- R9: An EOI naming a source that is not pending has no effect on that source.
- R10: While one source waits out its retry holdoff, other ready sources are still requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sig | input | NUM_SRC | Signal level for each source |
| cfg_we | input | 1 | Write strobe for the configuration of one source |
| cfg_idx | input | SRC_W | Source to configure |
| cfg_prio | input | 4 | Priority; lower value is more urgent, all ones means disabled |
| cfg_global | input | 1 | 1 = send to the shared queue, 0 = send to one CPU |
| cfg_cpu | input | 3 | Target CPU thread number |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_src | input | SRC_W | Source named by the EOI |
| req_valid | output | 1 | Request outstanding toward the CPU side |
| req_src | output | SRC_W | Requesting source number |
| req_prio | output | 4 | Priority of the request |
| req_global | output | 1 | Request goes to the shared queue |
| req_cpu | output | 3 | Target CPU thread of the request |
| rsp_accept | input | 1 | CPU side takes the outstanding request |
| rsp_reject | input | 1 | CPU side refuses the outstanding request |

## Verification
On every cycle the assertions check the following: an outstanding request stays stable until it is answered, a request never carries the disabled priority, a requesting source is always in the waiting state, accepts and EOIs move the state as required, and a rejected source is not ready in the cycle after the reject. Some properties can only be shown by the bench scenarios: the exact retry distance after a reject, the lowest-number-first order when sources collide, the latching of a disabled source that later becomes enabled, the ignored EOI, and re-presentation while the signal level stays high after an EOI.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    localparam int PRIO_W = 4;
    localparam int CPU_W  = 3;

    localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_PEND = 2'b10
    } src_state_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              glob;
        logic [CPU_W-1:0]  cpu;
    } dest_cfg_t;

    localparam dest_cfg_t CFG_RESET = '{prio: PRIO_OFF, glob: 1'b0, cpu: '0};

    function automatic logic prio_enabled(input logic [PRIO_W-1:0] p);
        return p != PRIO_OFF;
    endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_src_pkg::*;
#(
    parameter int RETRY_HOLD = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sig,
    input  logic       cfg_we,
    input  dest_cfg_t  cfg_d,
    input  logic       eoi_hit,
    input  logic       acc_hit,
    input  logic       rej_hit,
    output src_state_e st_q,
    output dest_cfg_t  cfg_q,
    output logic       ready
);
    localparam int HOLD_W = $clog2(RETRY_HOLD + 1);
    localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(RETRY_HOLD);

    logic [HOLD_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cfg_q  <= CFG_RESET;
            hold_q <= '0;
        end else begin
            if (cfg_we)
                cfg_q <= cfg_d;

            if (rej_hit)
                hold_q <= HOLD_INIT;
            else if (hold_q != '0)
                hold_q <= hold_q - 1'b1;

            unique case (st_q)
                ST_IDLE: if (sig)     st_q <= ST_WAIT;
                ST_WAIT: if (acc_hit) st_q <= ST_PEND;
                ST_PEND: if (eoi_hit) st_q <= ST_IDLE;
                default:              st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb
        ready = (st_q == ST_WAIT) && (hold_q == '0) && prio_enabled(cfg_q.prio);

    assert_no_ready_after_reject_R6: assert property (@(posedge clk) disable iff (rst)
        rej_hit |=> !ready)
        else $error("rejected source ready too early");

    assert_pend_needs_eoi_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PEND && !eoi_hit) |=> st_q == ST_PEND)
        else $error("pending source left without EOI");

endmodule

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
    parameter int NUM_SRC = 8,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] ready,
    output logic               any,
    output logic [SRC_W-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (ready[i]) begin
                any = 1'b1;
                idx = SRC_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_src_req.sv
module irq_src_req
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pick_any,
    input  logic [SRC_W-1:0] pick_idx,
    input  dest_cfg_t        pick_cfg,
    input  logic             rsp_accept,
    input  logic             rsp_reject,
    output logic             req_valid,
    output logic [SRC_W-1:0] req_src,
    output dest_cfg_t        req_cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_src   <= '0;
            req_cfg   <= CFG_RESET;
        end else if (req_valid) begin
            if (rsp_accept || rsp_reject)
                req_valid <= 1'b0;
        end else if (pick_any) begin
            req_valid <= 1'b1;
            req_src   <= pick_idx;
            req_cfg   <= pick_cfg;
        end
    end

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_accept && !rsp_reject) |=>
            (req_valid && $stable(req_src) && $stable(req_cfg)))
        else $error("request changed before response");

    assert_drop_on_rsp_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (rsp_accept || rsp_reject)) |=> !req_valid)
        else $error("request not withdrawn after response");

    assert_prio_usable_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> prio_enabled(req_cfg.prio))
        else $error("request with disabled priority");

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int RETRY_HOLD = 16,
    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_sig,
    input  logic               cfg_we,
    input  logic [SRC_W-1:0]   cfg_idx,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               cfg_global,
    input  logic [CPU_W-1:0]   cfg_cpu,
    input  logic               eoi_valid,
    input  logic [SRC_W-1:0]   eoi_src,
    output logic               req_valid,
    output logic [SRC_W-1:0]   req_src,
    output logic [PRIO_W-1:0]  req_prio,
    output logic               req_global,
    output logic [CPU_W-1:0]   req_cpu,
    input  logic               rsp_accept,
    input  logic               rsp_reject
);
    src_state_e         st_arr  [NUM_SRC];
    dest_cfg_t          cfg_arr [NUM_SRC];
    logic [NUM_SRC-1:0] ready_vec;
    logic               pick_any;
    logic [SRC_W-1:0]   pick_idx;
    dest_cfg_t          pick_cfg;
    dest_cfg_t          req_cfg;
    dest_cfg_t          cfg_wr;

    always_comb cfg_wr = '{prio: cfg_prio, glob: cfg_global, cpu: cfg_cpu};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        logic sel_req;
        always_comb sel_req = req_valid && (req_src == SRC_W'(i));

        irq_src_slot #(.RETRY_HOLD(RETRY_HOLD)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .sig     (src_sig[i]),
            .cfg_we  (cfg_we && (cfg_idx == SRC_W'(i))),
            .cfg_d   (cfg_wr),
            .eoi_hit (eoi_valid && (eoi_src == SRC_W'(i))),
            .acc_hit (sel_req && rsp_accept),
            .rej_hit (sel_req && rsp_reject && !rsp_accept),
            .st_q    (st_arr[i]),
            .cfg_q   (cfg_arr[i]),
            .ready   (ready_vec[i])
        );
    end

    irq_src_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .ready (ready_vec),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    always_comb pick_cfg = cfg_arr[pick_idx];

    irq_src_req #(.NUM_SRC(NUM_SRC)) u_req (
        .clk        (clk),
        .rst        (rst),
        .pick_any   (pick_any),
        .pick_idx   (pick_idx),
        .pick_cfg   (pick_cfg),
        .rsp_accept (rsp_accept),
        .rsp_reject (rsp_reject),
        .req_valid  (req_valid),
        .req_src    (req_src),
        .req_cfg    (req_cfg)
    );

    always_comb begin
        req_prio   = req_cfg.prio;
        req_global = req_cfg.glob;
        req_cpu    = req_cfg.cpu;
    end

    assert_req_from_wait_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> st_arr[req_src] == ST_WAIT)
        else $error("request from a source not waiting");

    assert_accept_pending_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_accept) |=> st_arr[$past(req_src)] == ST_PEND)
        else $error("accepted source not pending");

    assert_eoi_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && st_arr[eoi_src] == ST_PEND) |=> st_arr[$past(eoi_src)] != ST_PEND)
        else $error("EOI did not clear pending");

endmodule

// File: tb/irq_src_ctrl_tb.sv
module irq_src_ctrl_tb;
    localparam int N     = 8;
    localparam int HOLD  = 16;

    typedef struct packed {
        logic [2:0] src;
        logic [3:0] prio;
        logic       glob;
        logic [2:0] cpu;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 4'd0,  1'b0, 3'd5},
        '{3'd4, 4'd7,  1'b1, 3'd0},
        '{3'd7, 4'd14, 1'b0, 3'd7},
        '{3'd2, 4'd9,  1'b1, 3'd3},
        '{3'd5, 4'd1,  1'b0, 3'd1},
        '{3'd6, 4'd12, 1'b1, 3'd6}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src_sig = '0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_idx = '0;
    logic [3:0]   cfg_prio = '0;
    logic         cfg_global = 1'b0;
    logic [2:0]   cfg_cpu = '0;
    logic         eoi_valid = 1'b0;
    logic [2:0]   eoi_src = '0;
    logic         req_valid;
    logic [2:0]   req_src;
    logic [3:0]   req_prio;
    logic         req_global;
    logic [2:0]   req_cpu;
    logic         rsp_accept = 1'b0;
    logic         rsp_reject = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    irq_src_ctrl #(.NUM_SRC(N), .RETRY_HOLD(HOLD)) u_dut (
        .clk(clk), .rst(rst), .src_sig(src_sig),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio),
        .cfg_global(cfg_global), .cfg_cpu(cfg_cpu),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
        .req_global(req_global), .req_cpu(req_cpu),
        .rsp_accept(rsp_accept), .rsp_reject(rsp_reject)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] s, input logic [3:0] p, input logic g, input logic [2:0] c);
        cfg_we = 1'b1; cfg_idx = s; cfg_prio = p; cfg_global = g; cfg_cpu = c;
        tick;
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        src_sig = m;
        tick;
        src_sig = '0;
    endtask

    task automatic do_accept;
        rsp_accept = 1'b1;
        tick;
        rsp_accept = 1'b0;
    endtask

    task automatic do_reject;
        rsp_reject = 1'b1;
        tick;
        rsp_reject = 1'b0;
    endtask

    task automatic do_eoi(input logic [2:0] s);
        eoi_valid = 1'b1; eoi_src = s;
        tick;
        eoi_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) tick;
        rst = 1'b0;
        tick;

        // R1: reset state, disabled priority blocks requests
        chk("R1 req_valid after reset", 32'(req_valid), 32'd0);
        pulse(8'h01);
        tick; tick;
        chk("R1 no request at reset priority", 32'(req_valid), 32'd0);
        // R8: latched source fires once enabled
        set_cfg(3'd0, 4'd4, 1'b0, 3'd2);
        tick;
        chk("R8 latched src0 requests", 32'(req_valid), 32'd1);
        chk("R8 latched src0 number", 32'(req_src), 32'd0);
        do_accept;
        do_eoi(3'd0);

        // R2, R4, R5: vector table
        for (int v = 0; v < 6; v++) begin
            vec_t e;
            e = VECS[v];
            set_cfg(e.src, e.prio, e.glob, e.cpu);
            pulse(N'(1) << e.src);
            tick;
            chk("R2 req_valid", 32'(req_valid), 32'd1);
            chk("R2 req_src", 32'(req_src), 32'(e.src));
            chk("R2 req_prio", 32'(req_prio), 32'(e.prio));
            chk("R2 req_global", 32'(req_global), 32'(e.glob));
            chk("R2 req_cpu", 32'(req_cpu), 32'(e.cpu));
            do_accept;
            chk("R3 drop after accept", 32'(req_valid), 32'd0);
            pulse(N'(1) << e.src);
            tick; tick;
            chk("R4 pending blocks resignal", 32'(req_valid), 32'd0);
            do_eoi(e.src);
            pulse(N'(1) << e.src);
            tick;
            chk("R5 request after EOI", 32'(req_valid), 32'd1);
            chk("R5 source after EOI", 32'(req_src), 32'(e.src));
            do_accept;
            do_eoi(e.src);
        end

        // R3: held request stays stable
        pulse(8'h10);
        tick;
        repeat (3) tick;
        chk("R3 held valid", 32'(req_valid), 32'd1);
        chk("R3 held src", 32'(req_src), 32'd4);
        do_accept;
        do_eoi(3'd4);

        // R5: level still high across EOI
        src_sig = 8'h10;
        tick; tick;
        chk("R5 level request", 32'(req_valid), 32'd1);
        do_accept;
        do_eoi(3'd4);
        tick;
        chk("R5 level not yet", 32'(req_valid), 32'd0);
        tick;
        chk("R5 level re-request", 32'(req_valid), 32'd1);
        chk("R5 level src", 32'(req_src), 32'd4);
        src_sig = '0;
        do_accept;
        do_eoi(3'd4);

        // R6: exact retry distance
        set_cfg(3'd2, 4'd3, 1'b0, 3'd1);
        pulse(8'h04);
        tick;
        chk("R6 first request", 32'(req_valid), 32'd1);
        do_reject;
        n = 0;
        while (!req_valid && n < 40) begin
            tick;
            n++;
        end
        chk("R6 retry edge count", 32'(n), 32'(HOLD + 1));
        chk("R6 retry source", 32'(req_src), 32'd2);
        do_accept;
        do_eoi(3'd2);

        // R10: other source served during holdoff
        set_cfg(3'd5, 4'd1, 1'b1, 3'd2);
        pulse(8'h04);
        tick;
        do_reject;
        pulse(8'h20);
        tick;
        chk("R10 other source valid", 32'(req_valid), 32'd1);
        chk("R10 other source number", 32'(req_src), 32'd5);
        do_accept;
        do_eoi(3'd5);
        n = 0;
        while (!req_valid && n < 30) begin
            tick;
            n++;
        end
        chk("R6 retried after holdoff", 32'(req_src), 32'd2);
        do_accept;
        do_eoi(3'd2);

        // R7: lowest number wins
        set_cfg(3'd1, 4'd6, 1'b0, 3'd3);
        set_cfg(3'd6, 4'd2, 1'b0, 3'd4);
        pulse(8'h42);
        tick;
        chk("R7 lowest first", 32'(req_src), 32'd1);
        do_accept;
        chk("R7 gap after accept", 32'(req_valid), 32'd0);
        tick;
        chk("R7 second valid", 32'(req_valid), 32'd1);
        chk("R7 second source", 32'(req_src), 32'd6);
        do_accept;
        do_eoi(3'd1);
        do_eoi(3'd6);

        // R8, R9: disabled source latches, stray EOI ignored
        pulse(8'h08);
        tick; tick; tick;
        chk("R8 disabled stays quiet", 32'(req_valid), 32'd0);
        do_eoi(3'd3);
        tick;
        chk("R9 no request after stray EOI", 32'(req_valid), 32'd0);
        set_cfg(3'd3, 4'd2, 1'b1, 3'd0);
        tick;
        chk("R9 latch kept through EOI", 32'(req_valid), 32'd1);
        chk("R8 enabled source number", 32'(req_src), 32'd3);
        do_accept;
        do_eoi(3'd3);

        tick;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule